// File: doc/BRIEF.md
# Width-Adaptive Micropacket Link Serializer

This block carries fixed 160-bit micropackets across a parallel link. The link has two usable widths: a full 16-bit lane set, or only the low byte lane. The transmit half takes one micropacket at a time on a valid/ready stream and sends it as a run of beats. The 32-bit control part goes out first and the 128-bit payload follows it, with the most significant bits leading. A one-cycle start strobe marks the first beat of each packet. The receive half shifts the beats back in. When the final beat has arrived it presents the rebuilt micropacket with a one-cycle valid pulse.

An upper-lane fault input moves the link to byte-wide operation. The fault is latched and holds until reset. The new width is applied only at a packet boundary, meaning when the transmitter is idle or is sending its final beat, so a packet is never split across two widths. Both halves follow one shared width register, which is visible on a status pin. A packet takes 10 beats at full width and 20 beats at byte width.

On the input stream, back-pressure comes only from `in_ready`. The transmitter raises `in_ready` while idle and during the last beat of the current packet, which lets packets follow each other with no gap. `in_pkt` is sampled only on a cycle where `in_valid` and `in_ready` are both high. The receive output has no back-pressure: the rebuilt packet is valid for exactly the pulse cycle.

Top module: `mpl_link`

## Requirements
- R1: `in_ready` is high whenever no packet is being sent, and low during every beat of a packet except the last one.
- R2: In full-width mode, an accepted packet is sent on `tx_lane[15:0]` as 10 consecutive beats with `tx_beat` high. Beat k carries bits 159-16k down to 144-16k of the packet.
- R3: In byte-width mode, a packet is sent as 20 consecutive beats. Beat k carries bits 159-8k down to 152-8k on `tx_lane[7:0]`, and `tx_lane[15:8]` is driven to zero.
- R4: `tx_sop` is high for exactly one cycle per packet: the cycle of its first beat, and never without `tx_beat`.
- R5: A packet offered during the final beat of the previous one is accepted on that cycle. Accept cycles are then 10 apart at full width and 20 apart at byte width.
- R6: Once `upper_fault` has been high for one cycle, `narrow_mode` becomes 1 and stays 1 until reset, even after the fault input drops.
- R7: `narrow_mode` changes only on a clock edge where `in_ready` was high. A fault raised in the middle of a packet leaves that packet at its starting width.
- R8: The receiver raises `out_valid` for one cycle, in the cycle after the final beat of a packet that began with `rx_sop`. `out_pkt` then equals the packet that was sent.
- R9: A beat with `rx_sop` high always starts a new packet and discards any partial one.
- R10: Beats that arrive without a preceding `rx_sop` produce no `out_valid`.
- R11: A change of `narrow_mode` while the receiver holds a partial packet discards that partial packet. Later beats without `rx_sop` do not complete it.
- R12: After reset, `in_ready` is 1, `tx_beat`, `tx_sop` and `out_valid` are 0, and `narrow_mode` is 0 (full width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upper_fault | input | 1 | High when the upper byte lane is unusable; latched until reset |
| narrow_mode | output | 1 | Current link width: 1 = byte lane only, 0 = full width |
| in_valid | input | 1 | Micropacket offered on `in_pkt` |
| in_ready | output | 1 | Transmitter can take a micropacket this cycle |
| in_pkt | input | 160 | Micropacket; control in bits 159:128, payload in 127:0 |
| tx_beat | output | 1 | A beat is present on `tx_lane` |
| tx_sop | output | 1 | First beat of a micropacket |
| tx_lane | output | 16 | Transmit lane data |
| rx_beat | input | 1 | A beat is present on `rx_lane` |
| rx_sop | input | 1 | Received beat is the first of a micropacket |
| rx_lane | input | 16 | Receive lane data |
| out_valid | output | 1 | One-cycle pulse: `out_pkt` holds a rebuilt micropacket |
| out_pkt | output | 160 | Rebuilt micropacket |

## Verification
The hardest case to reach is a width change that lands while the receiver holds a partial packet. In a looped-back link this never happens, because the transmitter switches only between packets. To reach it, the bench cuts the loopback and drives the receive pins itself. It sends a start strobe and a few full-width beats, then raises the fault while the transmitter is idle, so the width flips at once. It then feeds exactly enough byte-wide beats to complete the stale count, and a correct receiver must stay silent. A second hard case is the fault raised in the middle of a full-width packet: the bench checks that the packet still runs to all 10 beats, that `narrow_mode` holds until the boundary, and that the next packet then leaves in 20 beats.

// File: rtl/mpl_pkg.sv
package mpl_pkg;
  localparam int MPL_PKT_W  = 160;
  localparam int MPL_LANE_W = 16;
endpackage

// File: rtl/mpl_lane_mode.sv
module mpl_lane_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic upper_fault,
  input  logic boundary,
  output logic narrow
);
  logic fault_q;
  logic fault_any;

  assign fault_any = fault_q | upper_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      narrow  <= 1'b0;
    end else begin
      fault_q <= fault_any;
      if (boundary) narrow <= fault_any;
    end
  end
endmodule

// File: rtl/mpl_tx.sv
module mpl_tx #(
  parameter int PKT_W  = mpl_pkg::MPL_PKT_W,
  parameter int LANE_W = mpl_pkg::MPL_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  output logic              tx_beat,
  output logic              tx_sop,
  output logic [LANE_W-1:0] tx_lane
);
  localparam int HALF = LANE_W / 2;
  localparam int WB   = PKT_W / LANE_W;
  localparam int NB   = PKT_W / HALF;
  localparam int CW   = $clog2(NB);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    last_idx;
  logic [PKT_W-1:0] shreg;
  logic             last;
  logic             accept;

  assign last_idx = narrow ? CW'(NB - 1) : CW'(WB - 1);
  assign last     = busy && (cnt == last_idx);
  assign in_ready = !busy || last;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      shreg <= in_pkt;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        cnt   <= cnt + CW'(1);
        shreg <= narrow ? (shreg << HALF) : (shreg << LANE_W);
      end
    end
  end

  assign tx_beat = busy;
  assign tx_sop  = busy && (cnt == '0);

  always_comb begin
    if (!busy)       tx_lane = '0;
    else if (narrow) tx_lane = {{(LANE_W-HALF){1'b0}}, shreg[PKT_W-1 -: HALF]};
    else             tx_lane = shreg[PKT_W-1 -: LANE_W];
  end
endmodule

// File: rtl/mpl_rx.sv
module mpl_rx #(
  parameter int PKT_W  = mpl_pkg::MPL_PKT_W,
  parameter int LANE_W = mpl_pkg::MPL_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              rx_beat,
  input  logic              rx_sop,
  input  logic [LANE_W-1:0] rx_lane,
  output logic              out_valid,
  output logic [PKT_W-1:0]  out_pkt
);
  localparam int HALF = LANE_W / 2;
  localparam int WB   = PKT_W / LANE_W;
  localparam int NB   = PKT_W / HALF;
  localparam int CW   = $clog2(NB);

  logic             active;
  logic             narrow_q;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    last_idx;
  logic [PKT_W-1:0] shreg;
  logic [PKT_W-1:0] shifted;

  assign last_idx = narrow ? CW'(NB - 1) : CW'(WB - 1);
  assign shifted  = narrow ? {shreg[PKT_W-HALF-1:0], rx_lane[HALF-1:0]}
                           : {shreg[PKT_W-LANE_W-1:0], rx_lane};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      narrow_q  <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_pkt   <= '0;
    end else begin
      narrow_q  <= narrow;
      out_valid <= 1'b0;
      if (rx_beat && rx_sop) begin
        shreg  <= shifted;
        cnt    <= CW'(1);
        active <= 1'b1;
      end else if (narrow != narrow_q) begin
        active <= 1'b0;
      end else if (rx_beat && active) begin
        shreg <= shifted;
        if (cnt == last_idx) begin
          active    <= 1'b0;
          out_valid <= 1'b1;
          out_pkt   <= shifted;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mpl_link.sv
module mpl_link #(
  parameter int PKT_W  = mpl_pkg::MPL_PKT_W,
  parameter int LANE_W = mpl_pkg::MPL_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upper_fault,
  output logic              narrow_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  output logic              tx_beat,
  output logic              tx_sop,
  output logic [LANE_W-1:0] tx_lane,
  input  logic              rx_beat,
  input  logic              rx_sop,
  input  logic [LANE_W-1:0] rx_lane,
  output logic              out_valid,
  output logic [PKT_W-1:0]  out_pkt
);
  mpl_lane_mode u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .upper_fault (upper_fault),
    .boundary    (in_ready),
    .narrow      (narrow_mode)
  );

  mpl_tx #(.PKT_W(PKT_W), .LANE_W(LANE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .narrow   (narrow_mode),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_pkt   (in_pkt),
    .tx_beat  (tx_beat),
    .tx_sop   (tx_sop),
    .tx_lane  (tx_lane)
  );

  mpl_rx #(.PKT_W(PKT_W), .LANE_W(LANE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .narrow    (narrow_mode),
    .rx_beat   (rx_beat),
    .rx_sop    (rx_sop),
    .rx_lane   (rx_lane),
    .out_valid (out_valid),
    .out_pkt   (out_pkt)
  );
endmodule

// File: rtl/mpl_link_chk.sv
module mpl_link_chk #(
  parameter int LANE_W = mpl_pkg::MPL_LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              narrow_mode,
  input logic              in_ready,
  input logic              tx_beat,
  input logic              tx_sop,
  input logic [LANE_W-1:0] tx_lane,
  input logic              rx_beat,
  input logic              out_valid
);
  localparam int HALF = LANE_W / 2;

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_beat |-> in_ready); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_beat && narrow_mode) |-> (tx_lane[LANE_W-1:HALF] == '0)); // R3
  AST_SOP_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> tx_beat); // R4
  AST_SOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |=> !tx_sop); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_mode |=> narrow_mode); // R6
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(narrow_mode)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8
  AST_VALID_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) && out_valid |-> $past(rx_beat)); // R8
endmodule

bind mpl_link mpl_link_chk #(.LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .narrow_mode (narrow_mode),
  .in_ready    (in_ready),
  .tx_beat     (tx_beat),
  .tx_sop      (tx_sop),
  .tx_lane     (tx_lane),
  .rx_beat     (rx_beat),
  .out_valid   (out_valid)
);

// File: tb/mpl_link_bench.sv
module mpl_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 160;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upper_fault = 1'b0;
  logic          narrow_mode;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_pkt = '0;
  logic          tx_beat, tx_sop;
  logic [LW-1:0] tx_lane;
  logic          sel_direct = 1'b0;
  logic          d_beat = 1'b0, d_sop = 1'b0;
  logic [LW-1:0] d_lane = '0;
  logic          rx_beat, rx_sop;
  logic [LW-1:0] rx_lane;
  logic          out_valid;
  logic [PW-1:0] out_pkt;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int rx_seen = 0;

  logic [PW-1:0] txq_pkt[$];
  bit            txq_nar[$];
  logic [PW-1:0] rxq[$];

  assign rx_beat = sel_direct ? d_beat : tx_beat;
  assign rx_sop  = sel_direct ? d_sop  : tx_sop;
  assign rx_lane = sel_direct ? d_lane : tx_lane;

  mpl_link u_mpl_link (
    .clk(clk), .rst_n(rst_n), .upper_fault(upper_fault), .narrow_mode(narrow_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .tx_beat(tx_beat), .tx_sop(tx_sop), .tx_lane(tx_lane),
    .rx_beat(rx_beat), .rx_sop(rx_sop), .rx_lane(rx_lane),
    .out_valid(out_valid), .out_pkt(out_pkt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // transmit-side monitor: beat contents and beat count per packet
  bit            tx_open = 1'b0;
  bit            tx_nar = 1'b0;
  int            tx_idx = 0;
  logic [PW-1:0] tx_cur = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tx_open = 1'b0;
    end else begin
      if (tx_open && (!tx_beat || tx_sop)) begin
        chk(tx_idx == (tx_nar ? 20 : 10), "R2 R3 beat count", PW'(tx_idx), PW'(tx_nar ? 20 : 10));
        tx_open = 1'b0;
      end
      if (tx_beat) begin
        if (tx_sop) begin
          if (txq_pkt.size() == 0) begin
            chk(1'b0, "R4 unexpected start strobe", 1, 0);
          end else begin
            tx_cur  = txq_pkt.pop_front();
            tx_nar  = txq_nar.pop_front();
            tx_open = 1'b1;
            tx_idx  = 0;
          end
        end else if (!tx_open) begin
          chk(1'b0, "R4 beat without start strobe", 1, 0);
        end
        if (tx_open) begin
          logic [PW-1:0] sh;
          logic [LW-1:0] exp;
          sh  = tx_cur << (tx_nar ? 8*tx_idx : 16*tx_idx);
          exp = tx_nar ? {8'h00, sh[PW-1 -: 8]} : sh[PW-1 -: 16];
          chk(tx_lane == exp, tx_nar ? "R3 lane value" : "R2 lane value", PW'(tx_lane), PW'(exp));
          tx_idx++;
        end
      end
    end
  end

  // receive-side scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      rx_seen++;
      if (rxq.size() == 0) begin
        chk(1'b0, "R8 R10 R11 unexpected out_valid", out_pkt, 0);
      end else begin
        logic [PW-1:0] e;
        e = rxq.pop_front();
        chk(out_pkt == e, "R8 rebuilt packet", out_pkt, e);
      end
    end
  end

  task automatic send(input logic [PW-1:0] p, input bit nar, input bit loop, output int acc);
    bit rdy;
    @(negedge clk);
    in_valid = 1'b1;
    in_pkt   = p;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1;
    acc = cyc;
    in_valid = 1'b0;
    txq_pkt.push_back(p);
    txq_nar.push_back(nar);
    if (loop) rxq.push_back(p);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_beat) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R12 in_ready after reset", PW'(in_ready), 1);
    chk(!tx_beat && !tx_sop, "R12 tx idle after reset", PW'({tx_beat, tx_sop}), 0);
    chk(out_valid == 1'b0, "R12 out_valid after reset", PW'(out_valid), 0);
    chk(narrow_mode == 1'b0, "R12 full width after reset", PW'(narrow_mode), 0);
  endtask

  task automatic dbeat(input logic [LW-1:0] lane, input bit sop);
    @(negedge clk);
    d_beat = 1'b1;
    d_sop  = sop;
    d_lane = lane;
  endtask

  task automatic dstop();
    @(negedge clk);
    d_beat = 1'b0;
    d_sop  = 1'b0;
    d_lane = '0;
  endtask

  task automatic run_all();
    int a0, a1, base;
    logic [PW-1:0] pa, pb, pc, pd, pe, pf, pg, ph, pj;
    pa = {32'hC0DE_0001, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210};
    pb = {32'hFFFF_0000, 32'hAAAA_5555, 32'h0F0F_F0F0, 32'h1111_2222, 32'h3333_4444};
    pc = {32'h8000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h5A5A_A5A5};
    pd = {32'h1357_9BDF, 32'h2468_ACE0, 32'h0BAD_F00D, 32'hCAFE_BABE, 32'h0000_00FF};
    pe = {32'hA1B2_C3D4, 32'hE5F6_0718, 32'h293A_4B5C, 32'h6D7E_8F90, 32'h1234_5678};
    pf = {32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004, 32'h0000_0005};
    pg = {32'hF00D_CAFE, 32'h9999_8888, 32'h7777_6666, 32'h5555_4444, 32'h3333_2222};
    ph = {32'h4242_4242, 32'h1010_0101, 32'hBEEF_0BAD, 32'h0C0C_C0C0, 32'h7E7E_8181};
    pj = {32'h6B6B_0F0F, 32'h3C3C_C3C3, 32'h0001_0203, 32'h0405_0607, 32'h0809_0A0B};

    do_reset();

    // R1: ready drops during a packet
    send(pa, 1'b0, 1'b1, a0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready low mid packet", PW'(in_ready), 0);
    wait_idle();

    // R5: back-to-back at full width
    send(pb, 1'b0, 1'b1, a0);
    send(pc, 1'b0, 1'b1, a1);
    chk(a1 - a0 == 10, "R5 full-width accept spacing", PW'(a1 - a0), 10);
    wait_idle();

    // R10: beats with no start strobe
    sel_direct = 1'b1;
    base = rx_seen;
    for (int i = 0; i < 10; i++) dbeat(16'h1234 + 16'(i), 1'b0);
    dstop();
    repeat (3) @(negedge clk);
    chk(rx_seen == base, "R10 no output without start strobe", PW'(rx_seen), PW'(base));

    // R9: partial packet overtaken by a new start strobe
    base = rx_seen;
    for (int i = 0; i < 5; i++) dbeat(16'hEE00 + 16'(i), i == 0);
    rxq.push_back(pd);
    for (int i = 0; i < 10; i++) begin
      logic [PW-1:0] s;
      s = pd << (16*i);
      dbeat(s[PW-1 -: 16], i == 0);
    end
    dstop();
    repeat (3) @(negedge clk);
    chk(rx_seen == base + 1, "R9 restart yields one packet", PW'(rx_seen), PW'(base + 1));
    sel_direct = 1'b0;

    // R7: fault raised mid packet keeps full width until boundary
    send(pe, 1'b0, 1'b1, a0);
    @(negedge clk);
    @(negedge clk);
    upper_fault = 1'b1;
    @(negedge clk);
    upper_fault = 1'b0;
    chk(narrow_mode == 1'b0, "R7 width held mid packet", PW'(narrow_mode), 0);
    send(pf, 1'b1, 1'b1, a1);
    chk(a1 - a0 == 10, "R7 boundary accept after full packet", PW'(a1 - a0), 10);
    wait_idle();
    chk(narrow_mode == 1'b1, "R6 byte width after fault", PW'(narrow_mode), 1);

    // R6 R3 R5: fault released, still byte width, back-to-back
    send(pg, 1'b1, 1'b1, a0);
    send(ph, 1'b1, 1'b1, a1);
    chk(a1 - a0 == 20, "R5 byte-width accept spacing", PW'(a1 - a0), 20);
    wait_idle();
    chk(narrow_mode == 1'b1, "R6 fault sticky", PW'(narrow_mode), 1);

    // R11: width change drops a partial packet
    do_reset();
    sel_direct = 1'b1;
    base = rx_seen;
    for (int i = 0; i < 5; i++) dbeat(16'hAB00 + 16'(i), i == 0);
    @(negedge clk);
    d_beat = 1'b0; d_sop = 1'b0;
    upper_fault = 1'b1;
    @(negedge clk);
    upper_fault = 1'b0;
    chk(narrow_mode == 1'b1, "R11 width flipped while idle", PW'(narrow_mode), 1);
    for (int i = 0; i < 15; i++) dbeat(16'h00C0 + 16'(i), 1'b0);
    dstop();
    repeat (3) @(negedge clk);
    chk(rx_seen == base, "R11 partial packet dropped", PW'(rx_seen), PW'(base));
    rxq.push_back(pj);
    for (int i = 0; i < 20; i++) begin
      logic [PW-1:0] s;
      s = pj << (8*i);
      dbeat({8'h00, s[PW-1 -: 8]}, i == 0);
    end
    dstop();
    repeat (3) @(negedge clk);
    chk(rx_seen == base + 1, "R11 R8 byte-width packet after drop", PW'(rx_seen), PW'(base + 1));
    sel_direct = 1'b0;

    chk(txq_pkt.size() == 0, "R2 all sent packets observed", PW'(txq_pkt.size()), 0);
    chk(rxq.size() == 0, "R8 all packets rebuilt", PW'(rxq.size()), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule